// File: doc/BRIEF.md
# Byte-serial command deserializer

This block sits on a narrow command bus that carries register writes one byte per clock. A transfer opens with a start strobe that comes with its first byte. The block collects the two address bytes and the data bytes that follow on back-to-back cycles. It rebuilds a 16-bit address and a 32-bit data word from them.

Many such blocks can share one bus. Each instance compares the rebuilt address with its own base under a mask. Only a matching instance emits a write. That write is a one-cycle enable, together with the address bits below the mask and the data word. The registers that take the write sit outside this block, and so does the master that sends the bytes.

Top module: `cmd_deser_win`

## Requirements
- R1: While reset is high, and in the first cycle after it, `wr_en` is 0, `wr_data` is 0 and `wr_addr` is 0.
- R2: A command has six bytes on consecutive cycles. Byte 0 is address bits 7:0 and byte 1 is address bits 15:8. Bytes 2, 3, 4 and 5 are data bits 7:0, 15:8, 23:16 and 31:24, so the first data byte is the least significant.
- R3: `cmd_stb` is high only with byte 0. A byte presented while no command is open and `cmd_stb` is low is ignored: no write follows from it.
- R4: An address `a` matches when `(a & ADDR_MASK) == (BASE_ADDR & ADDR_MASK)`. With the defaults (base 0x160, mask 0x3F8), address bits 15:10 are ignored. `wr_addr` carries the address bits below the lowest set mask bit, which is 3 bits with the default mask.
- R5: For a matching command, `wr_en` is high for exactly one cycle: the cycle right after the one in which the last data byte is on the bus.
- R6: A command whose address does not match produces no `wr_en` and leaves `wr_addr` and `wr_data` unchanged. Its bytes are still consumed, so none of them is taken as the start of a new command.
- R7: A strobe that comes while a command is still open drops the partial command and starts a new one with that byte as byte 0.
- R8: `wr_addr` and `wr_data` change only in a cycle where `wr_en` is high, and keep their value until the next accepted write.
- R9: A strobe in the cycle right after the last byte of a command starts a new command, so commands may run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Command byte on the serial bus |
| cmd_stb | input | 1 | High with the first byte of a command |
| wr_en | output | 1 | One-cycle write enable for a matching command |
| wr_addr | output | ADDR_LOW_W (3) | Address bits below the mask |
| wr_data | output | 32 | Assembled data word |

## Verification
The bench sends matching commands to several addresses, including ones that differ only in the ignored high bits. This separates correct mask handling from a full 16-bit compare. It also checks that the low bits come out unchanged. Non-matching commands are placed between matching ones, so a write that leaks through, or an output that changes after a rejected command, shows up at once. Idle bytes without a strobe, a command cut short by a new strobe, and back-to-back commands each test the byte counter's framing on its own. A wrong byte position, a missed restart or a stale count would give a different write, or a write in a different cycle, from what the reference model expects.

// File: rtl/cmdd_pkg.sv
package cmdd_pkg;

  // Number of zero bits below the lowest set bit of a mask (the low address width)
  function automatic int trailing_zeros(input logic [15:0] m);
    int n;
    n = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) break;
      n++;
    end
    return n;
  endfunction

  // Address window test: all bits selected by the mask agree with the base
  function automatic logic addr_hit(input logic [15:0] a, input logic [15:0] base,
                                    input logic [15:0] mask);
    return ((a ^ base) & mask) == 16'h0000;
  endfunction

endpackage

// File: rtl/cmdd_seq.sv
module cmdd_seq #(
  parameter int TOTAL = 6,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  output logic             byte_valid,
  output logic [IDX_W-1:0] byte_idx,
  output logic             last_byte
);
  logic             busy;
  logic [IDX_W-1:0] next_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      next_idx <= '0;
    end else if (strobe) begin
      busy     <= 1'b1;
      next_idx <= IDX_W'(1);
    end else if (busy) begin
      if (next_idx == IDX_W'(TOTAL - 1)) busy <= 1'b0;
      else next_idx <= next_idx + IDX_W'(1);
    end
  end

  always_comb begin
    byte_valid = strobe | busy;
    byte_idx   = strobe ? '0 : next_idx;
    last_byte  = byte_valid && (byte_idx == IDX_W'(TOTAL - 1));
  end

  // After the final byte, only a new strobe opens a byte slot
  assert_frame_closes_R3: assert property (@(posedge clk) disable iff (rst)
    last_byte |=> (byte_valid == strobe));

  // A strobe always restarts at byte 0
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (byte_idx == '0) && !last_byte);
endmodule

// File: rtl/cmdd_frame.sv
module cmdd_frame #(
  parameter int TOTAL = 6,
  localparam int IDX_W   = $clog2(TOTAL),
  localparam int FRAME_W = TOTAL * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         byte_in,
  input  logic               byte_valid,
  input  logic [IDX_W-1:0]   byte_idx,
  output logic [FRAME_W-1:0] frame_now
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst) frame_q <= '0;
    else if (byte_valid) frame_q[int'(byte_idx)*8 +: 8] <= byte_in;
  end

  // Current view of the frame including the byte on the bus this cycle
  always_comb begin
    frame_now = frame_q;
    if (byte_valid) frame_now[int'(byte_idx)*8 +: 8] = byte_in;
  end
endmodule

// File: rtl/cmdd_decode.sv
module cmdd_decode #(
  parameter int          FRAME_W = 48,
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 32,
  parameter int          LOW_W   = 3,
  parameter logic [15:0] BASE    = 16'h0160,
  parameter logic [15:0] MASK    = 16'h03F8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               last_byte,
  input  logic [FRAME_W-1:0] frame_now,
  output logic               wr_en,
  output logic [LOW_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]  wr_data
);
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              hit;
  logic              accept;

  always_comb begin
    cmd_addr = frame_now[ADDR_W-1:0];
    cmd_data = DATA_W'(frame_now[FRAME_W-1:ADDR_W]);
    hit      = cmdd_pkg::addr_hit(cmd_addr, BASE, MASK);
    accept   = last_byte && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= accept;
      if (accept) begin
        wr_addr <= cmd_addr[LOW_W-1:0];
        wr_data <= cmd_data;
      end
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  assert_write_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(last_byte));

  assert_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (last_byte && !hit) |=> !wr_en);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> ($stable(wr_data) && $stable(wr_addr)));
endmodule

// File: rtl/cmd_deser_win.sv
module cmd_deser_win #(
  parameter logic [15:0] BASE_ADDR  = 16'h0160,
  parameter logic [15:0] ADDR_MASK  = 16'h03F8,
  parameter int          DATA_BYTES = 4,
  parameter int          ADDR_LOW_W = cmdd_pkg::trailing_zeros(ADDR_MASK)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            cmd_byte,
  input  logic                  cmd_stb,
  output logic                  wr_en,
  output logic [ADDR_LOW_W-1:0] wr_addr,
  output logic [31:0]           wr_data
);
  localparam int ADDR_BYTES = 2;
  localparam int TOTAL      = ADDR_BYTES + DATA_BYTES;
  localparam int IDX_W      = $clog2(TOTAL);
  localparam int FRAME_W    = TOTAL * 8;

  logic               byte_valid;
  logic [IDX_W-1:0]   byte_idx;
  logic               last_byte;
  logic [FRAME_W-1:0] frame_now;

  cmdd_seq #(.TOTAL(TOTAL)) u_seq (
    .clk(clk), .rst(rst), .strobe(cmd_stb),
    .byte_valid(byte_valid), .byte_idx(byte_idx), .last_byte(last_byte)
  );

  cmdd_frame #(.TOTAL(TOTAL)) u_frame (
    .clk(clk), .rst(rst), .byte_in(cmd_byte),
    .byte_valid(byte_valid), .byte_idx(byte_idx), .frame_now(frame_now)
  );

  cmdd_decode #(
    .FRAME_W(FRAME_W), .ADDR_W(8 * ADDR_BYTES), .DATA_W(32),
    .LOW_W(ADDR_LOW_W), .BASE(BASE_ADDR), .MASK(ADDR_MASK)
  ) u_decode (
    .clk(clk), .rst(rst), .last_byte(last_byte), .frame_now(frame_now),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // A strobe opens a fresh command, so no write can follow it directly
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !wr_en);

  // Writes start only from a frame that began with a strobe (R3)
  assert_idle_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (!byte_valid && !cmd_stb) |=> !wr_en);
endmodule

// File: tb/cmd_deser_win_bench.sv
module cmd_deser_win_bench;
  localparam logic [15:0] BASE = 16'h0160;
  localparam logic [15:0] MASK = 16'h03F8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmd_byte = 8'h00;
  logic        cmd_stb = 1'b0;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    obs_writes = 0;
  string tag = "R1";

  // Reference model state
  int          pos = -1;
  logic [7:0]  got [6];
  logic        exp_en = 1'b0;
  logic [2:0]  exp_addr = 3'd0;
  logic [31:0] exp_data = 32'd0;

  always #2 clk = ~clk;

  cmd_deser_win u_cmd_deser_win (
    .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_stb(cmd_stb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Behavioural reference: collect bytes, decide on the sixth one
  always @(posedge clk) begin
    if (rst) begin
      pos = -1; exp_en = 1'b0; exp_addr = 3'd0; exp_data = 32'd0;
    end else begin
      int a;
      exp_en = 1'b0;
      if (cmd_stb) begin
        pos = 0; got[0] = cmd_byte;
      end else if (pos >= 0) begin
        pos = pos + 1; got[pos] = cmd_byte;
      end
      if (pos == 5) begin
        a = got[0] + 256 * got[1];
        if ((a % 1024) / 8 == int'(BASE[9:3])) begin
          exp_en   = 1'b1;
          exp_addr = 3'(a % 8);
          exp_data = {got[5], got[4], got[3], got[2]};
        end
        pos = -1;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (wr_en) obs_writes++;
      if (wr_en !== exp_en || wr_addr !== exp_addr || wr_data !== exp_data) begin
        errors++;
        $display("FAIL %s cycle %0d: actual en=%b addr=%0d data=%h expected en=%b addr=%0d data=%h",
                 tag, cyc, wr_en, wr_addr, wr_data, exp_en, exp_addr, exp_data);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  task automatic put(input logic s, input logic [7:0] b);
    @(negedge clk);
    cmd_stb  = s;
    cmd_byte = b;
  endtask

  task automatic send(input logic [15:0] a, input logic [31:0] d, input int nbytes);
    logic [7:0] f [6];
    f[0] = a[7:0];   f[1] = a[15:8];
    f[2] = d[7:0];   f[3] = d[15:8]; f[4] = d[23:16]; f[5] = d[31:24];
    for (int i = 0; i < nbytes; i++) put(i == 0, f[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 8'h00);
  endtask

  task automatic expect_writes(input string t, input int n);
    checks++;
    if (obs_writes != n) begin
      errors++;
      $display("FAIL %s write count: actual=%0d expected=%0d", t, obs_writes, n);
    end
    obs_writes = 0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (wr_en !== 1'b0 || wr_addr !== 3'd0 || wr_data !== 32'd0) begin
      errors++;
      $display("FAIL R1 reset: actual en=%b addr=%0d data=%h expected 0 0 0", wr_en, wr_addr, wr_data);
    end
    rst = 1'b0;
    idle(2);

    // R2 R4 R5: basic matching write, byte order
    tag = "R2";
    send(16'h0160, 32'h12345678, 6); idle(3);
    expect_writes("R2", 1);
    checks++;
    if (wr_data !== 32'h12345678 || wr_addr !== 3'd0) begin
      errors++;
      $display("FAIL R2 data: actual=%h/%0d expected=12345678/0", wr_data, wr_addr);
    end

    // R4: low bits and ignored high bits
    tag = "R4";
    send(16'h0167, 32'hA5A5_0F0F, 6); idle(2);
    send(16'hFD63, 32'h0000_00FF, 6); idle(2);
    expect_writes("R4", 2);

    // R6: non-matching addresses, outputs held
    tag = "R6";
    send(16'h0170, 32'hDEADBEEF, 6); idle(2);
    send(16'h0158, 32'hCAFEF00D, 6); idle(2);
    expect_writes("R6", 0);
    checks++;
    if (wr_data !== 32'h0000_00FF || wr_addr !== 3'd3) begin
      errors++;
      $display("FAIL R6 hold: actual=%h/%0d expected=000000ff/3", wr_data, wr_addr);
    end

    // R3: unstrobed bytes while idle are ignored (one looks like a base address)
    tag = "R3";
    put(1'b0, 8'h60); put(1'b0, 8'h01); put(1'b0, 8'h11);
    put(1'b0, 8'h22); put(1'b0, 8'h33); put(1'b0, 8'h44); idle(3);
    expect_writes("R3", 0);

    // R7: abort a partial command with a new strobe
    tag = "R7";
    send(16'h0161, 32'h11111111, 4);
    send(16'h0162, 32'h22222222, 6); idle(3);
    expect_writes("R7", 1);
    send(16'h0170, 32'h0, 3);            // non-matching prefix aborted by matching command
    send(16'h0164, 32'h44444444, 6); idle(3);
    expect_writes("R7", 1);

    // R9: back-to-back commands, mixed match
    tag = "R9";
    send(16'h0165, 32'h55555555, 6);
    send(16'h0265, 32'h66666666, 6);
    send(16'h0166, 32'h77777777, 6); idle(3);
    expect_writes("R9", 2);

    // R8: long idle, outputs stay put (checked every cycle by the model)
    tag = "R8";
    idle(20);
    checks++;
    if (wr_data !== 32'h77777777 || wr_addr !== 3'd6) begin
      errors++;
      $display("FAIL R8 hold: actual=%h/%0d expected=77777777/6", wr_data, wr_addr);
    end

    summary();
    $finish;
  end
endmodule